// File: doc/BRIEF.md
# Double-Buffered Backlight PWM Generator

This block produces one pulse-width modulated signal for a display backlight. A prescaler with a 10-bit divide field slows the input clock. A 12-bit period counter then runs on the slowed clock. A 13-bit high-width value sets how long the output stays high at the start of each period. The output is always normal polarity: every period starts high, then goes low for the rest of the period.

Software sets up the block through a small word-addressed register port. It has an address, a write strobe, write data, and combinational read data. Timing values are normally written into shadow copies. They move into the working copies only after a commit handshake: the commit bit is written to one and then written back to zero. A running output picks up the committed values at its next period boundary, so no shortened or stretched pulse appears. A disabled block picks them up on the next cycle. A two-bit mode field can select direct operation instead. In direct mode, timing writes update the working copies at once.

Top module: `bklt_pwm`

## Requirements
- R1: While enabled, one output period lasts (div+1)·(per+1) clock cycles. Here div is the working divider and per is the working period.
- R2: Each period starts with the high phase. The output is high for the first (div+1)·high cycles of the period and low for the rest, where 0 < high ≤ per.
- R3: A high width of 0 gives a constant low output. A high width greater than per gives a constant high output.
- R4: While the enable bit is 0, the output is low and both counters are held at zero. In the first cycle after the enable bit is written to 1, the block is at the start of a period: the output is high if high is nonzero.
- R5: In buffered mode, a timing write changes neither the working values nor the output until a commit.
- R6: A commit is complete when the commit bit is written to 1 and then written to 0. The shadow values then move into the working registers. This happens at the next period boundary while running, or one cycle after the commit write while disabled.
- R7: Writing the commit bit to 1 without a following 0 moves nothing.
- R8: Mode value 2'b11 selects direct mode, in which timing writes update the working registers in the next cycle. Every other mode value keeps buffered mode.
- R9: The register map is fixed:
  - 0x00: enable, bit 0.
  - 0x04: control 0, with the divider at bits 25:16.
  - 0x08: control 1, with the period at bits 11:0 and the high width at bits 28:16.
  - 0x0C: commit, bit 0.
  - 0x10: mode, bits 1:0.

  Reads of the control registers return the working values. All unused bits read as zero. Every register resets to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the counters and registers |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 5 | Byte address of the register being accessed |
| reg_we | input | 1 | Write strobe, sampled on the rising edge |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data for reg_addr |
| pwm_out | output | 1 | Backlight PWM output |

## Verification
A wrong counter or compare value shows up as a shifted edge on pwm_out within one period of the faulty setting. The bench compares the output on every cycle against the arithmetic waveform, across a sweep of divider, period and width values, so such an error cannot hide. A premature or lost working-register update is checked in two ways. The control-register read-back shows it in the same cycle. The output shows it in the cycles between the commit and the next period boundary, where the old and new widths give different levels.

// File: rtl/bklt_pwm_pkg.sv
package bklt_pwm_pkg;
   localparam logic [7:0] OFS_ENABLE = 8'h00;
   localparam logic [7:0] OFS_CTRL0  = 8'h04;
   localparam logic [7:0] OFS_CTRL1  = 8'h08;
   localparam logic [7:0] OFS_COMMIT = 8'h0C;
   localparam logic [7:0] OFS_MODE   = 8'h10;

   localparam logic [1:0] MODE_DIRECT = 2'b11;

   typedef enum logic [2:0] {
      SEL_NONE,
      SEL_ENABLE,
      SEL_CTRL0,
      SEL_CTRL1,
      SEL_COMMIT,
      SEL_MODE
   } reg_sel_e;
endpackage

// File: rtl/bklt_pwm_regs.sv
module bklt_pwm_regs
   import bklt_pwm_pkg::*;
#(
   parameter int ADDR_W   = 5,
   parameter int DIV_W    = 10,
   parameter int PER_W    = 12,
   parameter int HIGH_W   = 13,
   parameter int DIV_LSB  = 16,
   parameter int PER_LSB  = 0,
   parameter int HIGH_LSB = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic              reg_we,
   input  logic [31:0]       reg_wdata,
   input  logic              boundary,
   output logic              en_q,
   output logic [1:0]        mode_q,
   output logic              pending_q,
   output logic [DIV_W-1:0]  work_div,
   output logic [PER_W-1:0]  work_per,
   output logic [HIGH_W-1:0] work_high,
   output logic [31:0]       reg_rdata
);
   reg_sel_e          sel;
   logic              commit_q;
   logic [DIV_W-1:0]  sh_div;
   logic [PER_W-1:0]  sh_per;
   logic [HIGH_W-1:0] sh_high;
   logic              direct;
   logic              wr_en, wr_c0, wr_c1, wr_commit, wr_mode;
   logic              load;
   logic [DIV_W-1:0]  new_div;
   logic [PER_W-1:0]  new_per;
   logic [HIGH_W-1:0] new_high;

   always_comb begin
      sel = SEL_NONE;
      if      (reg_addr == ADDR_W'(OFS_ENABLE)) sel = SEL_ENABLE;
      else if (reg_addr == ADDR_W'(OFS_CTRL0))  sel = SEL_CTRL0;
      else if (reg_addr == ADDR_W'(OFS_CTRL1))  sel = SEL_CTRL1;
      else if (reg_addr == ADDR_W'(OFS_COMMIT)) sel = SEL_COMMIT;
      else if (reg_addr == ADDR_W'(OFS_MODE))   sel = SEL_MODE;
   end

   assign direct    = (mode_q == MODE_DIRECT);
   assign wr_en     = reg_we && (sel == SEL_ENABLE);
   assign wr_c0     = reg_we && (sel == SEL_CTRL0);
   assign wr_c1     = reg_we && (sel == SEL_CTRL1);
   assign wr_commit = reg_we && (sel == SEL_COMMIT);
   assign wr_mode   = reg_we && (sel == SEL_MODE);
   assign new_div   = reg_wdata[DIV_LSB  +: DIV_W];
   assign new_per   = reg_wdata[PER_LSB  +: PER_W];
   assign new_high  = reg_wdata[HIGH_LSB +: HIGH_W];

   // A committed update waits for a period boundary unless the output is idle.
   assign load = pending_q && (boundary || !en_q);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         en_q      <= 1'b0;
         mode_q    <= '0;
         commit_q  <= 1'b0;
         pending_q <= 1'b0;
         sh_div    <= '0;
         sh_per    <= '0;
         sh_high   <= '0;
         work_div  <= '0;
         work_per  <= '0;
         work_high <= '0;
      end else begin
         if (wr_en)   en_q   <= reg_wdata[0];
         if (wr_mode) mode_q <= reg_wdata[1:0];
         if (load) begin
            work_div  <= sh_div;
            work_per  <= sh_per;
            work_high <= sh_high;
            pending_q <= 1'b0;
         end
         if (wr_commit) begin
            commit_q <= reg_wdata[0];
            if (commit_q && !reg_wdata[0]) pending_q <= 1'b1;
         end
         if (wr_c0) begin
            sh_div <= new_div;
            if (direct) work_div <= new_div;
         end
         if (wr_c1) begin
            sh_per  <= new_per;
            sh_high <= new_high;
            if (direct) begin
               work_per  <= new_per;
               work_high <= new_high;
            end
         end
      end
   end

   always_comb begin
      reg_rdata = '0;
      case (sel)
         SEL_ENABLE: reg_rdata[0] = en_q;
         SEL_CTRL0:  reg_rdata[DIV_LSB +: DIV_W] = work_div;
         SEL_CTRL1: begin
            reg_rdata[PER_LSB  +: PER_W]  = work_per;
            reg_rdata[HIGH_LSB +: HIGH_W] = work_high;
         end
         SEL_COMMIT: reg_rdata[0]   = commit_q;
         SEL_MODE:   reg_rdata[1:0] = mode_q;
         default:    reg_rdata = '0;
      endcase
   end
endmodule

// File: rtl/bklt_pwm_prescale.sv
module bklt_pwm_prescale #(
   parameter int DIV_W = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic [DIV_W-1:0] limit,
   output logic             tick,
   output logic [DIV_W-1:0] count
);
   // The comparison uses >= so that a divider lowered mid-count still wraps.
   assign tick = en && (count >= limit);

   always_ff @(posedge clk) begin
      if (!rst_n || !en) count <= '0;
      else if (tick)     count <= '0;
      else               count <= count + 1'b1;
   end
endmodule

// File: rtl/bklt_pwm_period.sv
module bklt_pwm_period #(
   parameter int PER_W  = 12,
   parameter int HIGH_W = 13
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              tick,
   input  logic [PER_W-1:0]  work_per,
   input  logic [HIGH_W-1:0] work_high,
   output logic [PER_W-1:0]  count,
   output logic              boundary,
   output logic              pwm_raw
);
   localparam int CMP_W = ((PER_W > HIGH_W) ? PER_W : HIGH_W) + 1;

   assign boundary = tick && (count >= work_per);
   assign pwm_raw  = en && (CMP_W'(count) < CMP_W'(work_high));

   always_ff @(posedge clk) begin
      if (!rst_n || !en) count <= '0;
      else if (boundary) count <= '0;
      else if (tick)     count <= count + 1'b1;
   end
endmodule

// File: rtl/bklt_pwm.sv
module bklt_pwm #(
   parameter int ADDR_W  = 5,
   parameter int DIV_W   = 10,
   parameter int PER_W   = 12,
   parameter int HIGH_W  = 13,
   parameter bit OUT_REG = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic              reg_we,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata,
   output logic              pwm_out
);
   localparam int DIV_LSB  = 16;
   localparam int PER_LSB  = 0;
   localparam int HIGH_LSB = 16;

   if (ADDR_W < 5 || ADDR_W > 8) begin : g_bad_addr
      $error("ADDR_W must lie in 5..8");
   end
   if (DIV_W < 1 || DIV_LSB + DIV_W > 32) begin : g_bad_div
      $error("divider field does not fit control 0");
   end
   if (PER_W < 1 || PER_LSB + PER_W > HIGH_LSB) begin : g_bad_per
      $error("period field overlaps the high-width field");
   end
   if (HIGH_W < 1 || HIGH_LSB + HIGH_W > 32) begin : g_bad_high
      $error("high-width field does not fit control 1");
   end

   logic              en_q;
   logic [1:0]        mode_q;
   logic              pending_q;
   logic [DIV_W-1:0]  work_div;
   logic [PER_W-1:0]  work_per;
   logic [HIGH_W-1:0] work_high;
   logic              tick;
   logic              boundary;
   logic [DIV_W-1:0]  cnt_pre;
   logic [PER_W-1:0]  cnt_per;
   logic              pwm_raw;

   bklt_pwm_regs #(
      .ADDR_W(ADDR_W), .DIV_W(DIV_W), .PER_W(PER_W), .HIGH_W(HIGH_W),
      .DIV_LSB(DIV_LSB), .PER_LSB(PER_LSB), .HIGH_LSB(HIGH_LSB)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
      .reg_wdata(reg_wdata), .boundary(boundary), .en_q(en_q),
      .mode_q(mode_q), .pending_q(pending_q), .work_div(work_div),
      .work_per(work_per), .work_high(work_high), .reg_rdata(reg_rdata)
   );

   bklt_pwm_prescale #(.DIV_W(DIV_W)) u_pre (
      .clk(clk), .rst_n(rst_n), .en(en_q), .limit(work_div),
      .tick(tick), .count(cnt_pre)
   );

   bklt_pwm_period #(.PER_W(PER_W), .HIGH_W(HIGH_W)) u_per (
      .clk(clk), .rst_n(rst_n), .en(en_q), .tick(tick),
      .work_per(work_per), .work_high(work_high), .count(cnt_per),
      .boundary(boundary), .pwm_raw(pwm_raw)
   );

   if (OUT_REG) begin : g_out_reg
      logic pwm_q;
      always_ff @(posedge clk) begin
         if (!rst_n) pwm_q <= 1'b0;
         else        pwm_q <= pwm_raw;
      end
      assign pwm_out = pwm_q;
   end else begin : g_out_comb
      assign pwm_out = pwm_raw;
   end
endmodule

// File: rtl/bklt_pwm_chk.sv
module bklt_pwm_chk #(
   parameter int DIV_W  = 10,
   parameter int PER_W  = 12,
   parameter int HIGH_W = 13
) (
   input logic              clk,
   input logic              rst_n,
   input logic              en_q,
   input logic [1:0]        mode_q,
   input logic              pending_q,
   input logic              boundary,
   input logic [DIV_W-1:0]  cnt_pre,
   input logic [PER_W-1:0]  cnt_per,
   input logic [DIV_W-1:0]  work_div,
   input logic [PER_W-1:0]  work_per,
   input logic [HIGH_W-1:0] work_high,
   input logic              pwm_raw
);
   assert_low_when_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !en_q |-> !pwm_raw);

   assert_counters_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !en_q |=> (!en_q || (cnt_pre == '0 && cnt_per == '0)));

   assert_zero_width_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (work_high == '0) |-> !pwm_raw);

   assert_start_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(en_q) && work_high != '0) |-> pwm_raw);

   assert_buffered_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q != 2'b11 && !pending_q) |=>
         ($stable(work_div) && $stable(work_per) && $stable(work_high)));

   assert_commit_at_edge_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (en_q && mode_q != 2'b11 && !boundary) |=> $stable(work_high));
endmodule

bind bklt_pwm bklt_pwm_chk #(.DIV_W(DIV_W), .PER_W(PER_W), .HIGH_W(HIGH_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .en_q(en_q), .mode_q(mode_q),
   .pending_q(pending_q), .boundary(boundary), .cnt_pre(cnt_pre),
   .cnt_per(cnt_per), .work_div(work_div), .work_per(work_per),
   .work_high(work_high), .pwm_raw(pwm_raw)
);

// File: tb/bklt_pwm_tb.sv
module bklt_pwm_tb;
   localparam int CLK_PERIOD = 10;
   localparam logic [4:0] A_EN = 5'h00, A_C0 = 5'h04, A_C1 = 5'h08,
                          A_CM = 5'h0C, A_MD = 5'h10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [4:0]  reg_addr = '0;
   logic        reg_we = 1'b0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        pwm_out;

   int errors = 0;
   int checks = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   bklt_pwm u_dut (
      .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pwm_out(pwm_out)
   );

   task automatic check(input bit ok, input string req, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   // Called at a falling edge; returns at the next falling edge.
   task automatic wr(input logic [4:0] a, input logic [31:0] d);
      reg_addr  = a;
      reg_wdata = d;
      reg_we    = 1'b1;
      @(negedge clk);
      reg_we    = 1'b0;
   endtask

   task automatic rd(input logic [4:0] a, input logic [31:0] exp, input string req);
      reg_addr = a;
      #1;
      check(reg_rdata === exp, req, reg_rdata, exp);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("  Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog: actual=expired expected=finished");
      finish_run();
   end

   initial begin
      int bad;
      logic expv;
      logic actv;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R9: reset state of every register; R4: output idle
      rd(A_EN, 32'h0, "R9 enable reset");
      rd(A_C0, 32'h0, "R9 ctrl0 reset");
      rd(A_C1, 32'h0, "R9 ctrl1 reset");
      rd(A_CM, 32'h0, "R9 commit reset");
      rd(A_MD, 32'h0, "R9 mode reset");
      check(pwm_out === 1'b0, "R4 reset output", pwm_out, 0);

      // R9: unused bits read zero (direct mode so control reads follow writes)
      wr(A_MD, 32'hFFFF_FFFF);
      rd(A_MD, 32'h3, "R9 mode unused bits");
      wr(A_C0, 32'hFFFF_FFFF);
      rd(A_C0, 32'h03FF_0000, "R9 ctrl0 field");
      wr(A_C1, 32'hFFFF_FFFF);
      rd(A_C1, 32'h1FFF_0FFF, "R9 ctrl1 fields");
      wr(A_EN, 32'hFFFF_FFFF);
      rd(A_EN, 32'h1, "R9 enable unused bits");
      wr(A_EN, 32'h0);

      // R1 R2 R3 R4: sweep divider, period and width in direct mode
      for (int d = 0; d < 3; d++) begin
         for (int p = 0; p < 4; p++) begin
            for (int h = 0; h < 6; h++) begin
               logic fa, fe;
               wr(A_EN, 32'h0);
               wr(A_C0, 32'(d) << 16);
               wr(A_C1, (32'(h) << 16) | 32'(p));
               wr(A_EN, 32'h1);
               bad = 0;
               fa = 1'b0;
               fe = 1'b0;
               for (int k = 0; k < 2 * (d + 1) * (p + 1); k++) begin
                  expv = (((k / (d + 1)) % (p + 1)) < h);
                  if (pwm_out !== expv) begin
                     if (bad == 0) begin fa = pwm_out; fe = expv; end
                     bad++;
                  end
                  @(negedge clk);
               end
               if (h == 0 || h > p)
                  check(bad == 0, $sformatf("R3 R4 d=%0d p=%0d h=%0d", d, p, h), fa, fe);
               else
                  check(bad == 0, $sformatf("R1 R2 R4 d=%0d p=%0d h=%0d", d, p, h), fa, fe);
            end
         end
      end

      // Known working state: div 0, period 7, width 2
      wr(A_EN, 32'h0);
      wr(A_C0, 32'h0);
      wr(A_C1, 32'h0002_0007);

      // R8: mode 2'b01 keeps buffering
      wr(A_MD, 32'h1);
      wr(A_C0, 32'h0005_0000);
      rd(A_C0, 32'h0, "R8 mode 01 buffered");
      wr(A_C0, 32'h0);

      // R5: buffered write leaves working values alone
      wr(A_MD, 32'h0);
      wr(A_C1, 32'h0006_0007);
      rd(A_C1, 32'h0002_0007, "R5 buffered write");
      // R7: commit written to 1 only
      wr(A_CM, 32'h1);
      @(negedge clk);
      rd(A_C1, 32'h0002_0007, "R7 commit high alone");
      // R6: completing the handshake while disabled loads one cycle later
      wr(A_CM, 32'h0);
      @(negedge clk);
      rd(A_C1, 32'h0006_0007, "R6 idle commit");

      // Restore width 2 through the commit path
      wr(A_C1, 32'h0002_0007);
      wr(A_CM, 32'h1);
      wr(A_CM, 32'h0);
      @(negedge clk);

      // R6: running commit waits for the period boundary
      wr(A_EN, 32'h1);           // k = 0
      @(negedge clk);            // k = 1
      @(negedge clk);            // k = 2
      wr(A_C1, 32'h0005_0007);   // k = 3
      wr(A_CM, 32'h1);           // k = 4
      wr(A_CM, 32'h0);           // k = 5
      rd(A_C1, 32'h0002_0007, "R6 read before boundary");
      bad = 0;
      actv = 1'b0;
      expv = 1'b0;
      for (int k = 5; k < 16; k++) begin
         logic e;
         e = (k < 8) ? (k < 2) : ((k - 8) < 5);
         if (pwm_out !== e && bad == 0) begin actv = pwm_out; expv = e; end
         if (pwm_out !== e) bad++;
         @(negedge clk);
      end
      check(bad == 0, "R6 waveform across boundary", actv, expv);
      rd(A_C1, 32'h0005_0007, "R6 read after boundary");

      // R8: direct mode acts in the next cycle while running
      wr(A_MD, 32'h3);
      wr(A_C1, 32'h0000_0007);
      bad = 0;
      for (int k = 0; k < 8; k++) begin
         if (pwm_out !== 1'b0) bad++;
         @(negedge clk);
      end
      check(bad == 0, "R8 direct write to zero width", bad, 0);

      // R4: disabling while running drops the output
      wr(A_C1, 32'h0008_0007);
      check(pwm_out === 1'b1, "R3 width above period", pwm_out, 1);
      wr(A_EN, 32'h0);
      bad = 0;
      for (int k = 0; k < 8; k++) begin
         if (pwm_out !== 1'b0) bad++;
         @(negedge clk);
      end
      check(bad == 0, "R4 disabled output low", bad, 0);

      finish_run();
   end
endmodule